// File: doc/BRIEF.md
# Receive Overflow Truncation Stage

This stage sits between a receive MAC datapath and the client's streaming receive port. Beats arrive from the MAC with valid, start, end, empty and error fields, and they can never be held back. A small FIFO soaks up beats while the client lowers ready. When a beat arrives and the FIFO has no room, the stage cannot keep that beat. It reacts in one of two ways, depending on whether a frame is already open toward the client.

If the frame's start beat has already entered the FIFO, that frame is cut short. Every beat already stored still goes out first. The stage then adds one closing beat that carries an overflow error flag, and it throws away the rest of the input frame. If the beat that finds no room is a start beat, the whole incoming frame is thrown away and the client never sees any of it.

Top module: `rx_overflow_trunc`

## Requirements
- R1: A synchronous active-high reset empties the FIFO and clears the frame-open, truncation-pending and dropping state. In the cycle after reset, outValid is 0.
- R2: When there is no overflow, beats leave in arrival order. Data, start flag, end flag, empty and the error vector are unchanged.
- R3: An input beat is stored when the FIFO holds fewer than DEPTH beats. It is also stored when the FIFO is full but an output transfer (outValid and outReady both high) happens in the same cycle. Neither case is an overflow.
- R4: An overflow is an input beat with inValid high while the FIFO holds DEPTH beats and no output transfer happens in that cycle. The beat is discarded. An overflow can only happen while outReady is low.
- R5: On an overflow of a non-start beat in an open frame, all stored beats are delivered first. Then exactly one extra beat follows with outSop=0, outEop=1, outEmpty all ones, outData zero, and outErr with only bit 5 set. Bit 5 of the error vector means overflow, so ERR_W must be at least 6.
- R6: After a truncation, the remaining input beats of that frame are discarded, up to and including its input end beat. The end beat is discarded even when it is itself the overflowing beat. The next frame whose start beat arrives after the closing beat has left is delivered normally.
- R7: A start beat that overflows causes the whole frame to be dropped, through its end beat. This holds even if FIFO space frees up partway through the frame.
- R8: While outValid is high and outReady is low, outValid and every output field hold their values into the next cycle.
- R9: A start beat that arrives while a closing beat is still waiting to leave causes its frame to be dropped, even if FIFO space is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input beat present (cannot be stalled) |
| inSop | input | 1 | Input beat starts a frame |
| inEop | input | 1 | Input beat ends a frame |
| inData | input | DATA_W | Input beat data |
| inEmpty | input | EMPTY_W | Unused byte count of an end beat |
| inErr | input | ERR_W | Input error vector |
| outReady | input | 1 | Client can accept a beat |
| outValid | output | 1 | Output beat present |
| outSop | output | 1 | Output beat starts a frame |
| outEop | output | 1 | Output beat ends a frame |
| outData | output | DATA_W | Output beat data |
| outEmpty | output | EMPTY_W | Unused byte count of an end beat |
| outErr | output | ERR_W | Error vector; bit 5 marks overflow truncation |

## Verification
Two events can fall in the same cycle: an input beat arriving at a full FIFO, and an output beat being taken by the client. The bench provokes this by filling the FIFO with ready low, then raising ready on the exact cycle the next beat of the frame arrives. It judges the result by the output stream. The new beat must appear after the stored ones, and no closing error beat may appear. A second case checks the opposite outcome: a beat that overflows while ready stays low, followed later by ready returning. There the closing beat must appear once, and only after the FIFO has drained.

// File: rtl/rx_trunc_pkg.sv
package rx_trunc_pkg;

  // Input-side frame tracking state
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PASS    = 2'd1,
    ST_DISCARD = 2'd2,
    ST_DROP    = 2'd3
  } rx_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;          // store the current input beat
    logic truncPending;  // closing overflow beat waits behind stored beats
  } trunc_strobe_t;

endpackage

// File: rtl/rx_trunc_buf.sv
module rx_trunc_buf
  import rx_trunc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int EMPTY_W = 3,
  parameter int ERR_W   = 6,
  parameter int DEPTH   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  trunc_strobe_t       strobes,
  input  logic                inSop,
  input  logic                inEop,
  input  logic [DATA_W-1:0]   inData,
  input  logic [EMPTY_W-1:0]  inEmpty,
  input  logic [ERR_W-1:0]    inErr,
  input  logic                outReady,
  output logic                outValid,
  output logic                outSop,
  output logic                outEop,
  output logic [DATA_W-1:0]   outData,
  output logic [EMPTY_W-1:0]  outEmpty,
  output logic [ERR_W-1:0]    outErr,
  output logic                bufFull,
  output logic                bufEmpty,
  output logic                bufPop
);

  localparam int AW     = $clog2(DEPTH);
  localparam int BEAT_W = DATA_W + EMPTY_W + ERR_W + 2;
  localparam logic [ERR_W-1:0] OVF_ERR = ERR_W'(1) << 5;
  localparam logic [BEAT_W-1:0] TRUNC_BEAT =
    {1'b0, 1'b1, {EMPTY_W{1'b1}}, OVF_ERR, {DATA_W{1'b0}}};

  logic [BEAT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [AW:0]       count;
  logic [BEAT_W-1:0] inBeat, headBeat;

  assign inBeat   = {inSop, inEop, inEmpty, inErr, inData};
  assign headBeat = mem[rdPtr];

  assign bufEmpty = (count == '0);
  assign bufFull  = (count == (AW+1)'(DEPTH));
  assign bufPop   = outReady && !bufEmpty;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= inBeat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (bufPop)       rdPtr <= rdPtr + 1'b1;
      count <= count + (AW+1)'(strobes.push) - (AW+1)'(bufPop);
    end
  end

  assign outValid = !bufEmpty || strobes.truncPending;
  assign {outSop, outEop, outEmpty, outErr, outData} =
    bufEmpty ? TRUNC_BEAT : headBeat;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop)
      && $stable(outEop) && $stable(outEmpty) && $stable(outErr));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  // R5
  trunc_beat_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && bufEmpty |-> outEop && !outSop && outErr[5]);

endmodule

// File: rtl/rx_trunc_ctrl.sv
module rx_trunc_ctrl
  import rx_trunc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inSop,
  input  logic          inEop,
  input  logic          outReady,
  input  logic          bufFull,
  input  logic          bufEmpty,
  input  logic          bufPop,
  output trunc_strobe_t strobes
);

  rx_state_e state, stateNxt;
  logic      truncPending, setTrunc, room, push;

  assign room = !bufFull || bufPop;

  always_comb begin
    push     = 1'b0;
    setTrunc = 1'b0;
    stateNxt = state;
    if (inValid) begin
      if (inSop) begin
        if (!truncPending && room) begin
          push     = 1'b1;
          stateNxt = inEop ? ST_IDLE : ST_PASS;
        end else begin
          stateNxt = inEop ? ST_IDLE : ST_DROP;
        end
      end else if (state == ST_PASS) begin
        if (room) push = 1'b1;
        else      setTrunc = 1'b1;
        stateNxt = inEop ? ST_IDLE : (room ? ST_PASS : ST_DISCARD);
      end else if (inEop) begin
        stateNxt = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      truncPending <= 1'b0;
    end else begin
      state <= stateNxt;
      if (setTrunc)
        truncPending <= 1'b1;
      else if (truncPending && bufEmpty && outReady)
        truncPending <= 1'b0;
    end
  end

  assign strobes.push         = push;
  assign strobes.truncPending = truncPending;

  // R4
  overflow_ready_chk: assert property (@(posedge clk) disable iff (rst)
    inValid && bufFull && !bufPop |-> !outReady);

  // R7
  drop_no_push_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_DROP && !(inValid && inSop) |-> !strobes.push);

  // R9
  pending_no_push_chk: assert property (@(posedge clk) disable iff (rst)
    truncPending |-> !strobes.push);

  // R6
  discard_state_chk: assert property (@(posedge clk) disable iff (rst)
    setTrunc |=> truncPending && state != ST_PASS);

endmodule

// File: rtl/rx_overflow_trunc.sv
module rx_overflow_trunc
  import rx_trunc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int EMPTY_W = 3,
  parameter int ERR_W   = 6,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [DATA_W-1:0]  inData,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic [ERR_W-1:0]   inErr,
  input  logic               outReady,
  output logic               outValid,
  output logic               outSop,
  output logic               outEop,
  output logic [DATA_W-1:0]  outData,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic [ERR_W-1:0]   outErr
);

  trunc_strobe_t strobes;
  logic bufFull, bufEmpty, bufPop;

  rx_trunc_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady),
    .bufFull(bufFull), .bufEmpty(bufEmpty), .bufPop(bufPop),
    .strobes(strobes)
  );

  rx_trunc_buf #(
    .DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .ERR_W(ERR_W), .DEPTH(DEPTH)
  ) buf_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .inSop(inSop), .inEop(inEop), .inData(inData),
    .inEmpty(inEmpty), .inErr(inErr),
    .outReady(outReady),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outData(outData), .outEmpty(outEmpty), .outErr(outErr),
    .bufFull(bufFull), .bufEmpty(bufEmpty), .bufPop(bufPop)
  );

endmodule

// File: tb/rx_overflow_trunc_tb.sv
module rx_overflow_trunc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64, EMPTY_W = 3, ERR_W = 6, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 0, inSop = 0, inEop = 0, outReady = 0;
  logic [DATA_W-1:0] inData = '0;
  logic [EMPTY_W-1:0] inEmpty = '0;
  logic [ERR_W-1:0] inErr = '0;
  logic outValid, outSop, outEop;
  logic [DATA_W-1:0] outData;
  logic [EMPTY_W-1:0] outEmpty;
  logic [ERR_W-1:0] outErr;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_overflow_trunc #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .ERR_W(ERR_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .inEmpty(inEmpty), .inErr(inErr), .outReady(outReady),
    .outValid(outValid), .outSop(outSop), .outEop(outEop), .outData(outData),
    .outEmpty(outEmpty), .outErr(outErr));

  // Row: [23]vi [22]sop [21]eop [20:13]tag [12]rdy | [11]ov [10]sop [9]eop [8]err5 [7:0]tag
  localparam int NROWS = 29;
  localparam logic [23:0] VEC [NROWS] = '{
    {3'b110, 8'hA1, 1'b1, 4'b0000, 8'h00},
    {3'b101, 8'hA2, 1'b1, 4'b1100, 8'hA1},
    {3'b000, 8'h00, 1'b1, 4'b1010, 8'hA2},
    {3'b000, 8'h00, 1'b1, 4'b0000, 8'h00},
    {3'b110, 8'hB1, 1'b0, 4'b0000, 8'h00},
    {3'b100, 8'hB2, 1'b0, 4'b1100, 8'hB1},
    {3'b100, 8'hB3, 1'b0, 4'b1100, 8'hB1},
    {3'b100, 8'hB4, 1'b0, 4'b1100, 8'hB1},
    {3'b100, 8'hB5, 1'b0, 4'b1100, 8'hB1},
    {3'b101, 8'hB6, 1'b0, 4'b1100, 8'hB1},
    {3'b110, 8'hC1, 1'b1, 4'b1100, 8'hB1},
    {3'b101, 8'hC2, 1'b1, 4'b1000, 8'hB2},
    {3'b000, 8'h00, 1'b1, 4'b1000, 8'hB3},
    {3'b000, 8'h00, 1'b1, 4'b1000, 8'hB4},
    {3'b000, 8'h00, 1'b1, 4'b1011, 8'h00},
    {3'b000, 8'h00, 1'b1, 4'b0000, 8'h00},
    {3'b110, 8'hD1, 1'b0, 4'b0000, 8'h00},
    {3'b100, 8'hD2, 1'b0, 4'b1100, 8'hD1},
    {3'b100, 8'hD3, 1'b0, 4'b1100, 8'hD1},
    {3'b101, 8'hD4, 1'b0, 4'b1100, 8'hD1},
    {3'b110, 8'hE1, 1'b0, 4'b1100, 8'hD1},
    {3'b100, 8'hE2, 1'b1, 4'b1100, 8'hD1},
    {3'b101, 8'hE3, 1'b1, 4'b1000, 8'hD2},
    {3'b111, 8'h61, 1'b1, 4'b1000, 8'hD3},
    {3'b000, 8'h00, 1'b1, 4'b1010, 8'hD4},
    {3'b000, 8'h00, 1'b0, 4'b1110, 8'h61},
    {3'b000, 8'h00, 1'b0, 4'b1110, 8'h61},
    {3'b000, 8'h00, 1'b1, 4'b1110, 8'h61},
    {3'b000, 8'h00, 1'b1, 4'b0000, 8'h00}
  };

  function automatic string rowReq(int i);
    if (i < 4) return "R2";
    if (i >= 10 && i <= 13) return "R9";
    if (i == 14) return "R5";
    if (i < 16) return "R6";
    if (i == 25 || i == 26) return "R8";
    return "R7";
  endfunction

  // Drive one cycle (called at a falling edge), check outputs, advance one cycle.
  task automatic step(input logic vi, sop, eop, input logic [7:0] tag, input logic rdy,
                      input logic eov, esop, eeop, ee5, input logic [7:0] etag,
                      input string req);
    inValid = vi; inSop = sop; inEop = eop; inData = {56'h0, tag}; outReady = rdy;
    #1;
    total++;
    if (outValid !== eov || (eov && (outSop !== esop || outEop !== eeop ||
        outErr[5] !== ee5 || outData[7:0] !== etag))) begin
      bad++;
      $display("FAIL %s: actual v=%b s=%b e=%b e5=%b d=%h expected v=%b s=%b e=%b e5=%b d=%h",
               req, outValid, outSop, outEop, outErr[5], outData[7:0],
               eov, esop, eeop, ee5, etag);
    end
    @(negedge clk);
  endtask

  task automatic checkVal(input logic ok, input string req, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    checkVal(outValid === 1'b0, "R1", $sformatf("after reset outValid actual=%b expected=0", outValid));
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      step(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:13], VEC[i][12],
           VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], rowReq(i));
    end

    // R1: reset mid-stream discards stored beats
    step(1, 1, 0, 8'h11, 0, 0, 0, 0, 0, 8'h00, "R1");
    step(1, 0, 0, 8'h12, 0, 1, 1, 0, 0, 8'h11, "R1");
    inValid = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    checkVal(outValid === 1'b0, "R1", $sformatf("after mid-stream reset outValid actual=%b expected=0", outValid));
    @(negedge clk);

    // R2: empty and error vector pass through unchanged
    inErr = 6'b000101; inEmpty = 3'd2;
    step(1, 1, 1, 8'h21, 1, 0, 0, 0, 0, 8'h00, "R2");
    inErr = '0; inEmpty = '0;
    inValid = 0; outReady = 0;
    #1;
    checkVal(outValid && outErr === 6'b000101 && outEmpty === 3'd2 && outData[7:0] === 8'h21, "R2",
             $sformatf("err/empty actual=%b/%0d expected=000101/2", outErr, outEmpty));
    outReady = 1;
    @(negedge clk);

    // R3: full buffer with a transfer in the same cycle stores the beat
    step(1, 1, 0, 8'h91, 0, 0, 0, 0, 0, 8'h00, "R3");
    step(1, 0, 0, 8'h92, 0, 1, 1, 0, 0, 8'h91, "R3");
    step(1, 0, 0, 8'h93, 0, 1, 1, 0, 0, 8'h91, "R3");
    step(1, 0, 0, 8'h94, 0, 1, 1, 0, 0, 8'h91, "R3");
    step(1, 0, 1, 8'h95, 1, 1, 1, 0, 0, 8'h91, "R3");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h92, "R3");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h93, "R3");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h94, "R3");
    step(0, 0, 0, 8'h00, 1, 1, 0, 1, 0, 8'h95, "R3");
    step(0, 0, 0, 8'h00, 1, 0, 0, 0, 0, 8'h00, "R3");

    // R6: overflow on the end beat, then the next frame is delivered
    step(1, 1, 0, 8'h71, 0, 0, 0, 0, 0, 8'h00, "R6");
    step(1, 0, 0, 8'h72, 0, 1, 1, 0, 0, 8'h71, "R6");
    step(1, 0, 0, 8'h73, 0, 1, 1, 0, 0, 8'h71, "R6");
    step(1, 0, 0, 8'h74, 0, 1, 1, 0, 0, 8'h71, "R6");
    step(1, 0, 1, 8'h75, 0, 1, 1, 0, 0, 8'h71, "R6");
    step(0, 0, 0, 8'h00, 1, 1, 1, 0, 0, 8'h71, "R6");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h72, "R6");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h73, "R6");
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 8'h74, "R6");
    inValid = 0; outReady = 0;
    #1;
    checkVal(outValid && outEop && outEmpty === 3'b111 && outErr === 6'b100000 && outData === '0, "R5",
             $sformatf("closing beat empty/err/data actual=%b/%b/%h expected=111/100000/0",
                       outEmpty, outErr, outData));
    outReady = 1;
    @(negedge clk);
    step(1, 1, 1, 8'h81, 1, 0, 0, 0, 0, 8'h00, "R6");
    step(0, 0, 0, 8'h00, 1, 1, 1, 1, 0, 8'h81, "R6");
    step(0, 0, 0, 8'h00, 1, 0, 0, 0, 0, 8'h00, "R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule